// File: doc/BRIEF.md
# Reset Bus Park and Mode Strap Controller

This block decides what the local bus pins do while the chip reset request is active, and it picks the operating mode from strap levels sampled during that reset. Each pin group follows its own parking policy. The strobe, status and lock groups drive their inactive high level for one clock and are then released. The address-latch and hold-acknowledge group is held low for the whole reset. The multiplexed address/data lines, the upper address lines, the byte-high enable and the direction pin are left undriven. Outside reset, none of its drive enables is active, so the normal bus controller owns the pins.

Four strap inputs have weak pullups, which the pads provide, so an open strap reads high. A low queue strap selects queue-status mode. Both chip-select straps low selects the emulation mode, in which the pads float all outputs. Enhanced mode needs the test strap to be low in some reset cycle and then high on the final one. The mode flags keep the values of the last reset clock until the next reset. The pad ring uses the per-pin enable and value outputs, and the core uses the mode flags.

Top module: `rbp_top`

## Requirements
- R1: `park_active_o` goes high on the first clock edge that samples `rst_req_i` high, and goes low on the first edge that samples it low.
- R2: The strobe group (bit 2 data enable, bit 1 read, bit 0 write), the status group and the lock output have their enables high, with all values 1, in exactly the first cycle of `park_active_o`. In every later cycle of `park_active_o` they are released, with enables and values 0.
- R3: While `park_active_o` is high, both bits of the hold group (bit 1 address latch enable, bit 0 hold acknowledge) have their enables at 1 and their values at 0.
- R4: The float group never has an enable set. Its bits, from LSB, are the address/data lines, then the upper address lines, then byte-high enable, then direction.
- R5: While `park_active_o` is low, every enable and value output is 0.
- R6: Queue-status mode (`mode_qs_o`) is set when `qs_strap_i` was low on the last clock edge of reset and the emulation condition did not hold.
- R7: Emulation mode (`mode_oce_o`) is set when `ucs_strap_i` and `lcs_strap_i` were both low on the last reset edge. It takes priority, so `mode_qs_o` is then 0.
- R8: `mode_enh_o` is set only when `test_strap_i` was low on some earlier edge of the same reset and high on its last edge. A reset lasting one clock never sets it.
- R9: Strap changes outside reset have no effect, and the mode flags stay constant until the next reset. With no strap condition met, all flags are 0 (normal mode).
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rst_req_i | input | 1 | Chip reset request being serviced, active high |
| qs_strap_i | input | 1 | Queue-status strap level (low selects) |
| ucs_strap_i | input | 1 | Upper chip-select strap level |
| lcs_strap_i | input | 1 | Lower chip-select strap level |
| test_strap_i | input | 1 | Test strap level |
| park_active_o | output | 1 | Reset parking in progress |
| strb_oe_o | output | 3 | Strobe drive enables |
| strb_val_o | output | 3 | Strobe drive values |
| stat_oe_o | output | ST_W | Status drive enables |
| stat_val_o | output | ST_W | Status drive values |
| lock_oe_o | output | 1 | Lock drive enable |
| lock_val_o | output | 1 | Lock drive value |
| hold_oe_o | output | 2 | Latch-enable / hold-ack drive enables |
| hold_val_o | output | 2 | Latch-enable / hold-ack drive values |
| float_oe_o | output | AD_W+UA_W+2 | Floated-group drive enables |
| float_val_o | output | AD_W+UA_W+2 | Floated-group drive values |
| mode_qs_o | output | 1 | Queue-status mode |
| mode_oce_o | output | 1 | Emulation (float) mode |
| mode_enh_o | output | 1 | Enhanced mode |

## Verification
Two events can land in the same cycle. The one-clock drive pulse and the final strap capture coincide when a reset lasts a single clock. The start of a new reset can also come right after a one-cycle gap, while the previous reset's enhanced-mode history is still stored. The bench provokes both cases with a one-cycle reset and with back-to-back resets. It holds the test strap low in the previous reset so that stale history would show. A behavioural model tracks each reset's cycle index and strap history, and every output is compared against it on every clock.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  typedef enum logic [1:0] {
    POL_PULSE_HIGH = 2'd0,
    POL_HOLD_LOW   = 2'd1,
    POL_FLOAT      = 2'd2
  } park_policy_e;

  localparam int unsigned STRB_W = 3;
  localparam int unsigned HOLD_W = 2;
endpackage

// File: rtl/rbp_park_group.sv
module rbp_park_group
  import rbp_pkg::*;
#(
  parameter park_policy_e POLICY = POL_FLOAT,
  parameter int unsigned  WIDTH  = 1
) (
  input  logic             active_i,
  input  logic             first_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] val_o
);
  if (POLICY == POL_PULSE_HIGH) begin : g_pulse
    assign oe_o  = {WIDTH{active_i & first_i}};
    assign val_o = {WIDTH{active_i & first_i}};
  end else if (POLICY == POL_HOLD_LOW) begin : g_hold
    assign oe_o  = {WIDTH{active_i}};
    assign val_o = '0;
  end else begin : g_float
    assign oe_o  = '0;
    assign val_o = '0;
  end
endmodule

// File: rtl/rbp_strap_decode.sv
module rbp_strap_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic fresh_i,
  input  logic qs_i,
  input  logic ucs_i,
  input  logic lcs_i,
  input  logic test_i,
  output logic qs_o,
  output logic oce_o,
  output logic enh_o
);
  logic low_seen_q;
  logic prior_low;
  logic oce_hit;

  // history from earlier edges of this reset only
  assign prior_low = low_seen_q & ~fresh_i;
  assign oce_hit   = ~ucs_i & ~lcs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_seen_q <= 1'b0;
      qs_o       <= 1'b0;
      oce_o      <= 1'b0;
      enh_o      <= 1'b0;
    end else if (sample_i) begin
      low_seen_q <= prior_low | ~test_i;
      oce_o      <= oce_hit;
      qs_o       <= ~qs_i & ~oce_hit;
      enh_o      <= prior_low & test_i;
    end
  end

  a_r8_enh_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enh_o) |-> $past(sample_i & test_i & ~fresh_i));
  a_r7_oce_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(qs_o && oce_o));
endmodule

// File: rtl/rbp_top.sv
module rbp_top
  import rbp_pkg::*;
#(
  parameter int unsigned AD_W = 16,
  parameter int unsigned UA_W = 4,
  parameter int unsigned ST_W = 3,
  localparam int unsigned FL_W = AD_W + UA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              qs_strap_i,
  input  logic              ucs_strap_i,
  input  logic              lcs_strap_i,
  input  logic              test_strap_i,
  output logic              park_active_o,
  output logic [STRB_W-1:0] strb_oe_o,
  output logic [STRB_W-1:0] strb_val_o,
  output logic [ST_W-1:0]   stat_oe_o,
  output logic [ST_W-1:0]   stat_val_o,
  output logic              lock_oe_o,
  output logic              lock_val_o,
  output logic [HOLD_W-1:0] hold_oe_o,
  output logic [HOLD_W-1:0] hold_val_o,
  output logic [FL_W-1:0]   float_oe_o,
  output logic [FL_W-1:0]   float_val_o,
  output logic              mode_qs_o,
  output logic              mode_oce_o,
  output logic              mode_enh_o
);
  logic in_rst_q;
  logic first_q;
  logic fresh;

  assign fresh = rst_req_i & ~in_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      in_rst_q <= rst_req_i;
      first_q  <= fresh;
    end
  end

  assign park_active_o = in_rst_q;

  rbp_park_group #(.POLICY(POL_PULSE_HIGH), .WIDTH(STRB_W)) i_strb (
    .active_i(in_rst_q), .first_i(first_q), .oe_o(strb_oe_o), .val_o(strb_val_o));
  rbp_park_group #(.POLICY(POL_PULSE_HIGH), .WIDTH(ST_W)) i_stat (
    .active_i(in_rst_q), .first_i(first_q), .oe_o(stat_oe_o), .val_o(stat_val_o));
  rbp_park_group #(.POLICY(POL_PULSE_HIGH), .WIDTH(1)) i_lock (
    .active_i(in_rst_q), .first_i(first_q), .oe_o(lock_oe_o), .val_o(lock_val_o));
  rbp_park_group #(.POLICY(POL_HOLD_LOW), .WIDTH(HOLD_W)) i_hold (
    .active_i(in_rst_q), .first_i(first_q), .oe_o(hold_oe_o), .val_o(hold_val_o));
  rbp_park_group #(.POLICY(POL_FLOAT), .WIDTH(FL_W)) i_float (
    .active_i(in_rst_q), .first_i(first_q), .oe_o(float_oe_o), .val_o(float_val_o));

  rbp_strap_decode i_straps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(rst_req_i),
    .fresh_i (fresh),
    .qs_i    (qs_strap_i),
    .ucs_i   (ucs_strap_i),
    .lcs_i   (lcs_strap_i),
    .test_i  (test_strap_i),
    .qs_o    (mode_qs_o),
    .oce_o   (mode_oce_o),
    .enh_o   (mode_enh_o)
  );

  a_r1_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> park_active_o);
  a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_oe_o[0] |=> !strb_oe_o[0] && !stat_oe_o[0] && !lock_oe_o);
  a_r2_pulse_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(park_active_o) |-> (&strb_val_o) && (&stat_val_o) && lock_val_o);
  a_r3_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_active_o |-> (&hold_oe_o) && (hold_val_o == '0));
  a_r5_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !park_active_o |-> !(|strb_oe_o) && !(|stat_oe_o) && !lock_oe_o && !(|hold_oe_o));
  a_r9_modes_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_i |=> $stable({mode_qs_o, mode_oce_o, mode_enh_o}));
endmodule

// File: tb/test_rbp_top.sv
module test_rbp_top;
  localparam int AD_W = 16;
  localparam int UA_W = 4;
  localparam int ST_W = 3;
  localparam int FL_W = AD_W + UA_W + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_req = 1'b0;
  logic qs = 1'b1, ucs = 1'b1, lcs = 1'b1, tst = 1'b1;

  logic            park;
  logic [2:0]      strb_oe, strb_val;
  logic [ST_W-1:0] stat_oe, stat_val;
  logic            lock_oe, lock_val;
  logic [1:0]      hold_oe, hold_val;
  logic [FL_W-1:0] fl_oe, fl_val;
  logic            m_qs, m_oce, m_enh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rbp_top #(.AD_W(AD_W), .UA_W(UA_W), .ST_W(ST_W)) i_rbp_top (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req),
    .qs_strap_i(qs), .ucs_strap_i(ucs), .lcs_strap_i(lcs), .test_strap_i(tst),
    .park_active_o(park), .strb_oe_o(strb_oe), .strb_val_o(strb_val),
    .stat_oe_o(stat_oe), .stat_val_o(stat_val), .lock_oe_o(lock_oe), .lock_val_o(lock_val),
    .hold_oe_o(hold_oe), .hold_val_o(hold_val), .float_oe_o(fl_oe), .float_val_o(fl_val),
    .mode_qs_o(m_qs), .mode_oce_o(m_oce), .mode_enh_o(m_enh));

  // reference model
  bit in_rst_m = 0;
  int cyc_m = 0;
  bit low_hist_m = 0;
  bit qs_m = 0, oce_m = 0, enh_m = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_m = 0; cyc_m = 0; low_hist_m = 0; qs_m = 0; oce_m = 0; enh_m = 0;
    end else if (rst_req) begin
      if (!in_rst_m) begin cyc_m = 0; low_hist_m = 0; end
      else cyc_m = cyc_m + 1;
      enh_m = low_hist_m && tst;
      if (!tst) low_hist_m = 1;
      oce_m = !ucs && !lcs;
      qs_m  = !qs && !oce_m;
      in_rst_m = 1;
    end else begin
      in_rst_m = 0;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit first;
      first = in_rst_m && (cyc_m == 0);
      chk("R1 park_active", 64'(park), 64'(in_rst_m));
      chk("R2 strobe oe", 64'(strb_oe), first ? 64'h7 : 64'h0);
      chk("R2 strobe val", 64'(strb_val), first ? 64'h7 : 64'h0);
      chk("R2 status oe", 64'(stat_oe), first ? 64'((1 << ST_W) - 1) : 64'h0);
      chk("R2 status val", 64'(stat_val), first ? 64'((1 << ST_W) - 1) : 64'h0);
      chk("R2 lock", 64'({lock_oe, lock_val}), first ? 64'h3 : 64'h0);
      chk("R3/R5 hold oe", 64'(hold_oe), in_rst_m ? 64'h3 : 64'h0);
      chk("R3 hold val", 64'(hold_val), 64'h0);
      chk("R4 float oe", 64'(fl_oe), 64'h0);
      chk("R4 float val", 64'(fl_val), 64'h0);
      chk("R6 mode_qs", 64'(m_qs), 64'(qs_m));
      chk("R7 mode_oce", 64'(m_oce), 64'(oce_m));
      chk("R8 mode_enh", 64'(m_enh), 64'(enh_m));
    end
  end

  task automatic drive(bit r, bit q, bit u, bit l, bit t, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rst_req = r; qs = q; ucs = u; lcs = l; tst = t;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: block reset clears every output
    chk("R10 outputs in block reset",
        64'({park, strb_oe, stat_oe, lock_oe, hold_oe, |fl_oe, m_qs, m_oce, m_enh}), 64'h0);
    #1 rst_ni = 1'b1;
    drive(0, 1, 1, 1, 1, 3);
    drive(1, 1, 1, 1, 1, 5);          // R9 normal mode, R2 pulse
    drive(0, 1, 1, 1, 1, 4);
    drive(1, 0, 1, 1, 1, 4);          // R6 queue mode
    drive(0, 1, 0, 0, 0, 4);          // R9 straps ignored outside reset
    chk("R9 modes held", 64'({m_qs, m_oce, m_enh}), 64'h4);
    drive(1, 0, 0, 0, 1, 3);          // R7 emulation beats queue
    drive(0, 1, 1, 1, 1, 3);
    drive(1, 1, 1, 1, 0, 3);          // R8 low then high
    drive(1, 1, 1, 1, 1, 2);
    drive(0, 1, 1, 1, 1, 3);
    drive(1, 1, 1, 1, 1, 2);          // R8 high then low: no enhanced
    drive(1, 1, 1, 1, 0, 1);
    drive(0, 1, 1, 1, 1, 3);
    drive(1, 1, 1, 1, 0, 2);          // history left from this reset
    drive(0, 1, 1, 1, 1, 1);          // one-cycle gap
    drive(1, 1, 1, 1, 1, 1);          // R8 one-cycle reset: stale history must not count
    drive(0, 1, 1, 1, 1, 3);
    chk("R8 one-cycle reset no enhanced", 64'(m_enh), 64'h0);
    drive(1, 0, 1, 0, 1, 1);          // one-cycle reset: pulse and capture coincide
    drive(0, 1, 1, 1, 1, 4);
    chk("R6 one-cycle capture", 64'({m_qs, m_oce}), 64'h2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule